// File: doc/BRIEF.md
# Peripheral interrupt flag register bank

This block gathers interrupt requests from sixteen peripheral sources into two 8-bit flag registers and merges them into one interrupt request line. Most sources deliver a one-cycle event strobe. The strobe sets a sticky flag, and that flag stays set until software clears it through the register port. Two sources are different. The serial receiver and the serial transmitter report buffer state as levels, and their flags follow those levels. These two flags cannot be written. They clear when the peripheral's data buffer is read (receive) or written (transmit), because that access changes the level.

A flag latches whatever the state of its enable bit and of the global enable. The per-bit enable mask and the global enable only decide whether a flag reaches the request output. That output is registered. A parameter selects the smaller package option, in which the parallel-port flag is reserved and held at zero. Each capture/compare flag ignores its events while its channel runs in PWM mode.

Top module: `irq_flag_bank`

## Requirements
- R1: After reset, both registers read 0x00 and `irq_o` is 0.
- R2: A strobe on `evt_i[i]` for a sticky flag sets flag i on the next clock edge, even when `en_i[i]` and `gie_i` are both 0. Flag index i maps to register `i/8`, bit `i%8`.
- R3: A sticky flag holds its value until a register write. The write loads the written bit value, so writing 0 clears the flag and writing 1 sets it.
- R4: When an event strobe and a write of 0 reach the same sticky flag in the same cycle, the flag ends up set.
- R5: The receive flag (register 0 bit 5) equals `rx_full_i` as sampled at the previous clock edge. Writes and `evt_i[5]` do not change it.
- R6: The transmit flag (register 0 bit 4) equals `tx_empty_i` as sampled at the previous clock edge. Writes and `evt_i[4]` do not change it.
- R7: Events on capture/compare-1 (register 0 bit 2) are ignored while `ccp1_pwm_i` is 1. Events on capture/compare-2 (register 1 bit 0) are ignored while `ccp2_pwm_i` is 1.
- R8: With `HAS_PAR_PORT` = 0, register 0 bit 7 reads 0 whatever the events or writes.
- R9: `irq_o` is registered. It equals `gie_i` AND (OR over all bits of flags AND `en_i`), taken at the previous clock edge.
- R10: `reg_rdata_o` shows register `reg_addr_i` combinationally. Register 0, bit 7 down to bit 0: parallel port, ADC done, receive, transmit, serial port, capture/compare-1, timer2 match, timer1 overflow. Register 1, bit 7 down to bit 0: oscillator fail, comparator change, USB, nonvolatile write done, bus collision, voltage detect, timer3 overflow, capture/compare-2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| evt_i | input | 16 | One-cycle event strobes, one per flag index |
| ccp1_pwm_i | input | 1 | Capture/compare-1 channel is in PWM mode |
| ccp2_pwm_i | input | 1 | Capture/compare-2 channel is in PWM mode |
| rx_full_i | input | 1 | Receive buffer holds an unread byte |
| tx_empty_i | input | 1 | Transmit buffer is empty |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 1 | Register select |
| reg_wdata_i | input | 8 | Write data |
| reg_rdata_o | output | 8 | Read data of the selected register |
| en_i | input | 16 | Per-flag enable mask |
| gie_i | input | 1 | Global interrupt enable |
| irq_o | output | 1 | Combined interrupt request |

## Verification
The bench drives an event and a clearing write into the same cycle. A design that gave the write priority would lose that interrupt. It writes to the receive and transmit bits and fires strobes at them. A design that treated these bits as sticky would hold a stale flag after the buffer drains. It pulses capture/compare events while the channels are in PWM mode, and it runs a reserved-bit instance next to the normal one. A leaky gate or a missing tie-off would show up as a flag reading 1. It also times the request output edge by edge. An unregistered output, or one ignoring the global enable, would assert a cycle early or stay high when it should be low.

// File: rtl/irq_flag_pkg.sv
package irq_flag_pkg;
  typedef enum logic [2:0] {
    FK_STICKY,
    FK_PWM_GATED,
    FK_RX_LEVEL,
    FK_TX_LEVEL,
    FK_RESERVED
  } flag_kind_e;

  localparam int unsigned IDX_TMR1 = 0;
  localparam int unsigned IDX_TMR2 = 1;
  localparam int unsigned IDX_CCP1 = 2;
  localparam int unsigned IDX_SSP  = 3;
  localparam int unsigned IDX_TX   = 4;
  localparam int unsigned IDX_RX   = 5;
  localparam int unsigned IDX_ADC  = 6;
  localparam int unsigned IDX_PAR  = 7;
  localparam int unsigned IDX_CCP2 = 8;
  localparam int unsigned IDX_TMR3 = 9;
  localparam int unsigned IDX_HLVD = 10;
  localparam int unsigned IDX_BCOL = 11;
  localparam int unsigned IDX_NVM  = 12;
  localparam int unsigned IDX_USB  = 13;
  localparam int unsigned IDX_CMP  = 14;
  localparam int unsigned IDX_OSC  = 15;

  function automatic flag_kind_e flag_kind(int unsigned idx, bit has_par);
    if (idx == IDX_RX) return FK_RX_LEVEL;
    if (idx == IDX_TX) return FK_TX_LEVEL;
    if (idx == IDX_CCP1 || idx == IDX_CCP2) return FK_PWM_GATED;
    if (idx == IDX_PAR && !has_par) return FK_RESERVED;
    return FK_STICKY;
  endfunction
endpackage

// File: rtl/irq_flag_cell.sv
module irq_flag_cell
  import irq_flag_pkg::*;
#(
  parameter flag_kind_e KIND = FK_STICKY
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic evt_i,
  input  logic block_i,
  input  logic level_i,
  input  logic wr_i,
  input  logic wdata_i,
  output logic flag_o
);
  logic flag_q, flag_d;

  always_comb begin
    unique case (KIND)
      FK_STICKY:    flag_d = evt_i ? 1'b1 : (wr_i ? wdata_i : flag_q);
      // events count only outside PWM mode
      FK_PWM_GATED: flag_d = (evt_i && !block_i) ? 1'b1 : (wr_i ? wdata_i : flag_q);
      FK_RX_LEVEL,
      FK_TX_LEVEL:  flag_d = level_i;
      default:      flag_d = 1'b0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) flag_q <= 1'b0;
    else         flag_q <= flag_d;
  end

  assign flag_o = flag_q;
endmodule

// File: rtl/irq_req_merge.sv
module irq_req_merge #(
  parameter int unsigned N = 16
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] flags_i,
  input  logic [N-1:0] en_i,
  input  logic         gie_i,
  output logic         irq_o
);
  logic irq_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) irq_q <= 1'b0;
    else         irq_q <= gie_i && |(flags_i & en_i);
  end

  assign irq_o = irq_q;
endmodule

// File: rtl/irq_flag_bank.sv
module irq_flag_bank
  import irq_flag_pkg::*;
#(
  parameter int unsigned NUM_REGS     = 2,
  parameter int unsigned REG_W        = 8,
  parameter bit          HAS_PAR_PORT = 1'b1,
  localparam int unsigned NUM_FLAGS   = NUM_REGS * REG_W,
  localparam int unsigned ADDR_W      = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic [NUM_FLAGS-1:0] evt_i,
  input  logic                 ccp1_pwm_i,
  input  logic                 ccp2_pwm_i,
  input  logic                 rx_full_i,
  input  logic                 tx_empty_i,
  input  logic                 reg_we_i,
  input  logic [ADDR_W-1:0]    reg_addr_i,
  input  logic [REG_W-1:0]     reg_wdata_i,
  output logic [REG_W-1:0]     reg_rdata_o,
  input  logic [NUM_FLAGS-1:0] en_i,
  input  logic                 gie_i,
  output logic                 irq_o
);
  logic [NUM_FLAGS-1:0] flags;
  logic [REG_W-1:0]     regs [NUM_REGS];

  for (genvar i = 0; i < NUM_FLAGS; i++) begin : g_flag
    localparam flag_kind_e K = flag_kind(i, HAS_PAR_PORT);
    logic blk, lvl, wr;

    assign blk = (i == IDX_CCP1) ? ccp1_pwm_i :
                 (i == IDX_CCP2) ? ccp2_pwm_i : 1'b0;
    assign lvl = (i == IDX_RX) ? rx_full_i :
                 (i == IDX_TX) ? tx_empty_i : 1'b0;
    assign wr  = reg_we_i && (reg_addr_i == ADDR_W'(i / REG_W));

    irq_flag_cell #(.KIND(K)) u_cell (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .evt_i   (evt_i[i]),
      .block_i (blk),
      .level_i (lvl),
      .wr_i    (wr),
      .wdata_i (reg_wdata_i[i % REG_W]),
      .flag_o  (flags[i])
    );
  end

  for (genvar r = 0; r < NUM_REGS; r++) begin : g_view
    assign regs[r] = flags[r*REG_W +: REG_W];
  end

  assign reg_rdata_o = regs[reg_addr_i];

  irq_req_merge #(.N(NUM_FLAGS)) u_merge (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .flags_i (flags),
    .en_i    (en_i),
    .gie_i   (gie_i),
    .irq_o   (irq_o)
  );
endmodule

// File: rtl/irq_flag_bank_chk.sv
module irq_flag_bank_chk
  import irq_flag_pkg::*;
#(
  parameter int unsigned NUM_REGS     = 2,
  parameter int unsigned REG_W        = 8,
  parameter bit          HAS_PAR_PORT = 1'b1,
  localparam int unsigned NUM_FLAGS   = NUM_REGS * REG_W,
  localparam int unsigned ADDR_W      = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1
) (
  input logic                 clk_i,
  input logic                 rst_ni,
  input logic [NUM_FLAGS-1:0] evt_i,
  input logic                 ccp1_pwm_i,
  input logic                 ccp2_pwm_i,
  input logic                 rx_full_i,
  input logic                 tx_empty_i,
  input logic                 reg_we_i,
  input logic [ADDR_W-1:0]    reg_addr_i,
  input logic [REG_W-1:0]     reg_wdata_i,
  input logic [NUM_FLAGS-1:0] en_i,
  input logic                 gie_i,
  input logic                 irq_o,
  input logic [NUM_FLAGS-1:0] flags_i
);
  logic seen_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) seen_q <= 1'b0;
    else         seen_q <= 1'b1;
  end

  for (genvar i = 0; i < NUM_FLAGS; i++) begin : g_bit
    localparam flag_kind_e K = flag_kind(i, HAS_PAR_PORT);
    logic wr0;
    assign wr0 = reg_we_i && (reg_addr_i == ADDR_W'(i / REG_W)) && !reg_wdata_i[i % REG_W];
    if (K == FK_STICKY) begin : g_st
      assert_evt_sets_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        evt_i[i] |=> flags_i[i]);
      assert_sticky_hold_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (flags_i[i] && !wr0) |=> flags_i[i]);
      assert_evt_beats_clear_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (evt_i[i] && wr0) |=> flags_i[i]);
    end
  end

  assert_rx_follows_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    seen_q |=> flags_i[IDX_RX] == $past(rx_full_i));
  assert_tx_follows_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    seen_q |=> flags_i[IDX_TX] == $past(tx_empty_i));
  assert_pwm_gate1_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ccp1_pwm_i && !flags_i[IDX_CCP1] && !(reg_we_i && reg_addr_i == ADDR_W'(0)))
    |=> !flags_i[IDX_CCP1]);
  assert_pwm_gate2_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ccp2_pwm_i && !flags_i[IDX_CCP2] && !(reg_we_i && reg_addr_i == ADDR_W'(1)))
    |=> !flags_i[IDX_CCP2]);
  assert_irq_timing_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    seen_q |=> irq_o == ($past(gie_i) && |($past(flags_i) & $past(en_i))));
endmodule

bind irq_flag_bank irq_flag_bank_chk #(
  .NUM_REGS(NUM_REGS), .REG_W(REG_W), .HAS_PAR_PORT(HAS_PAR_PORT)
) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .evt_i(evt_i), .ccp1_pwm_i(ccp1_pwm_i),
  .ccp2_pwm_i(ccp2_pwm_i), .rx_full_i(rx_full_i), .tx_empty_i(tx_empty_i),
  .reg_we_i(reg_we_i), .reg_addr_i(reg_addr_i), .reg_wdata_i(reg_wdata_i),
  .en_i(en_i), .gie_i(gie_i), .irq_o(irq_o), .flags_i(flags)
);

// File: tb/test_irq_flag_bank.sv
module test_irq_flag_bank;
  localparam int unsigned CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] evt = '0;
  logic        pwm1 = 1'b0, pwm2 = 1'b0, rx_full = 1'b0, tx_empty = 1'b0;
  logic        we = 1'b0;
  logic        addr = 1'b0;
  logic [7:0]  wdata = '0;
  logic [15:0] en = '0;
  logic        gie = 1'b0;
  logic [7:0]  rdata, rdata_s;
  logic        irq, irq_s;
  int          n_chk = 0, n_fail = 0;
  bit          done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  irq_flag_bank i_irq_flag_bank (
    .clk_i(clk), .rst_ni(rst_n), .evt_i(evt), .ccp1_pwm_i(pwm1), .ccp2_pwm_i(pwm2),
    .rx_full_i(rx_full), .tx_empty_i(tx_empty), .reg_we_i(we), .reg_addr_i(addr),
    .reg_wdata_i(wdata), .reg_rdata_o(rdata), .en_i(en), .gie_i(gie), .irq_o(irq)
  );

  irq_flag_bank #(.HAS_PAR_PORT(1'b0)) i_irq_flag_bank_small (
    .clk_i(clk), .rst_ni(rst_n), .evt_i(evt), .ccp1_pwm_i(pwm1), .ccp2_pwm_i(pwm2),
    .rx_full_i(rx_full), .tx_empty_i(tx_empty), .reg_we_i(we), .reg_addr_i(addr),
    .reg_wdata_i(wdata), .reg_rdata_o(rdata_s), .en_i(en), .gie_i(gie), .irq_o(irq_s)
  );

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
  endtask

  task automatic rd(input logic a, output logic [7:0] v, output logic [7:0] vs);
    addr = a; #1; v = rdata; vs = rdata_s;
  endtask

  task automatic pulse(input int idx);
    evt[idx] = 1'b1; step(); evt = '0;
  endtask

  task automatic wr(input logic a, input logic [7:0] d);
    addr = a; wdata = d; we = 1'b1; step(); we = 1'b0;
  endtask

  task automatic t_reset();
    logic [7:0] v, vs;
    rd(0, v, vs); chk("R1 reg0", v, 8'h00);
    rd(1, v, vs); chk("R1 reg1", v, 8'h00);
    chk("R1 irq", {7'd0, irq}, 8'h00);
  endtask

  task automatic t_sticky();
    logic [7:0] v, vs;
    en = '0; gie = 1'b0;
    pulse(6); pulse(15);
    rd(0, v, vs); chk("R2 R10 adc in reg0", v, 8'h40);
    rd(1, v, vs); chk("R2 R10 osc in reg1", v, 8'h80);
    step(); step();
    rd(0, v, vs); chk("R3 hold", v, 8'h40);
    chk("R2 no irq when disabled", {7'd0, irq}, 8'h00);
    wr(0, 8'h00); wr(1, 8'h00);
    rd(0, v, vs); chk("R3 clear reg0", v, 8'h00);
    rd(1, v, vs); chk("R3 clear reg1", v, 8'h00);
    wr(1, 8'h01);
    rd(1, v, vs); chk("R3 write one sets", v, 8'h01);
    wr(1, 8'h00);
  endtask

  task automatic t_collide();
    logic [7:0] v, vs;
    evt[0] = 1'b1; addr = 0; wdata = 8'h00; we = 1'b1;
    step();
    evt = '0; we = 1'b0;
    rd(0, v, vs); chk("R4 event beats clear", v, 8'h01);
    wr(0, 8'h00);
  endtask

  task automatic t_rx_tx();
    logic [7:0] v, vs;
    rx_full = 1'b1; step();
    rd(0, v, vs); chk("R5 rx follows full", v, 8'h20);
    wr(0, 8'h00);
    rd(0, v, vs); chk("R5 rx write ignored", v, 8'h20);
    rx_full = 1'b0; step();
    rd(0, v, vs); chk("R5 rx clears on drain", v, 8'h00);
    wr(0, 8'h20); pulse(5);
    rd(0, v, vs); chk("R5 rx set attempts ignored", v, 8'h00);
    tx_empty = 1'b1; step();
    rd(0, v, vs); chk("R6 tx follows empty", v, 8'h10);
    wr(0, 8'h00);
    rd(0, v, vs); chk("R6 tx write ignored", v, 8'h10);
    tx_empty = 1'b0; step();
    wr(0, 8'h10); pulse(4);
    rd(0, v, vs); chk("R6 tx set attempts ignored", v, 8'h00);
  endtask

  task automatic t_pwm();
    logic [7:0] v, vs;
    pwm1 = 1'b1; pwm2 = 1'b1;
    pulse(2); pulse(8);
    rd(0, v, vs); chk("R7 ccp1 gated", v, 8'h00);
    rd(1, v, vs); chk("R7 ccp2 gated", v, 8'h00);
    pwm1 = 1'b0; pwm2 = 1'b0;
    pulse(2); pulse(8);
    rd(0, v, vs); chk("R7 ccp1 sets", v, 8'h04);
    rd(1, v, vs); chk("R7 ccp2 sets", v, 8'h01);
    wr(0, 8'h00); wr(1, 8'h00);
  endtask

  task automatic t_irq();
    en = 16'h0040; gie = 1'b1;
    pulse(6);
    chk("R9 irq one cycle late", {7'd0, irq}, 8'h00);
    step();
    chk("R9 irq asserted", {7'd0, irq}, 8'h01);
    gie = 1'b0; step();
    chk("R9 global gate", {7'd0, irq}, 8'h00);
    gie = 1'b1; en = 16'h0001; step();
    chk("R9 mask gate", {7'd0, irq}, 8'h00);
    en = 16'h0040; step();
    chk("R9 reenabled", {7'd0, irq}, 8'h01);
    wr(0, 8'h00); step();
    chk("R9 drops after clear", {7'd0, irq}, 8'h00);
    en = '0; gie = 1'b0;
  endtask

  task automatic t_reserved();
    logic [7:0] v, vs;
    en = 16'h0080; gie = 1'b1;
    pulse(7);
    rd(0, v, vs);
    chk("R8 full part sets par", v, 8'h80);
    chk("R8 reserved par stays 0", vs, 8'h00);
    step();
    chk("R8 reserved no irq", {7'd0, irq_s}, 8'h00);
    wr(0, 8'h00); wr(0, 8'h80);
    rd(0, v, vs); chk("R8 reserved write ignored", vs, 8'h00);
    wr(0, 8'h00);
    en = '0; gie = 1'b0;
  endtask

  initial begin
    step(); step(); step();
    rst_n = 1'b1;
    step();
    t_reset();
    t_sticky();
    t_collide();
    t_rx_tx();
    t_pwm();
    t_irq();
    t_reserved();
    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      done = 1'b1;
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule